// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte Lanes

This block is a single-clock synchronous static RAM for use as a burst-capable local store. On the rising edge it captures the address, the write data and every control input. The array is accessed on the next edge, and read data leaves through an output register. Either of two burst-start strobes opens an access. A 2-bit counter then walks through the four words of an aligned group. The counter moves forward only while the advance strobe is low. A mode pin chooses a wrapping linear order or an XOR (interleaved) order.

Writes are self-timed from the clock edge. A write covers any subset of the byte lanes, or it covers the whole word when the global write input is low. A start is accepted only when three chip enables agree, which allows several devices to share one bus. When an access ends, the data bus drive stays on for two more cycles before it is released. The bidirectional data bus is split into an input port, an output port and a drive-enable. The array size is set by parameters.

Top module: `burst_sram`

## Requirements
- R1: While `rst` is high on an edge, the burst state and the bus drive are cleared. After reset, `dout_en` is 0, and advance strobes given without a preceding start produce no access.
- R2: With `ilv_mode`=0, the beats of a burst started at address A use address bits above bit 1 taken from A, and low bits (A[1:0]+k) mod 4 for k = 0,1,2,3.
- R3: With `ilv_mode`=1, beat k uses low bits A[1:0] XOR k, and the upper bits stay those of A.
- R4: A continuation cycle with `adv_n` high repeats the current address. Only a cycle with `adv_n` low steps the counter.
- R5: A start strobe during a burst reloads the counter from the new address, and the following beats continue from that address.
- R6: A lane i (bits 8i+7..8i) is written only when `wr_byte_n`=0 and `lane_n[i]`=0. A cycle with `wr_all_n`=1 and no lane enabled is a read and changes no stored data.
- R7: `wr_all_n`=0 writes every lane whatever `lane_n` holds.
- R8: A start with `sel0_n`=1, `sel1`=0 or `sel2_n`=1 deselects the device. No write takes place, the burst ends, and no read drive begins.
- R9: Read data for an address sampled on edge N appears on `dout` after edge N+1. Until then `dout` keeps its previous value.
- R10: After a deselect is sampled on edge N+1 following a read, `dout_en` stays 1 after edges N+1 and N+2 and drops after edge N+3.
- R11: `dout_en` is 0 while `oe_n` is 1. A write cycle ends the drive one edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address, loaded on a start |
| bst_proc_n | input | 1 | Burst start strobe A, active low |
| bst_ctrl_n | input | 1 | Burst start strobe B, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_byte_n | input | 1 | Byte write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| sel0_n | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| sel2_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ilv_mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Bus drive enable |

## Verification
The bench uses the defaults: a 6-bit address (64 words), four 8-bit lanes and a two-cycle deselect hold. With only 64 words, every word can be loaded with a distinct value, so a wrong beat address always shows up as wrong data. Bursts are run from all four offsets in both orders, and also in the top group (60..63), so a carry into the upper address bits would be caught. The two-cycle hold is short enough to check the drive edge by edge.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int CNT_W = 2;
  typedef logic [CNT_W-1:0] beat_t;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} op_e;
endpackage

// File: rtl/burst_sram_capture.sv
module burst_sram_capture #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bst_proc_n,
  input  logic              bst_ctrl_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              ilv_mode,
  input  logic [DW-1:0]     din,
  output logic [ADDR_W-1:0] r_addr,
  output logic [DW-1:0]     r_din,
  output logic              r_start,
  output logic              r_sel,
  output logic              r_adv,
  output logic              r_wr_all,
  output logic              r_wr_byte,
  output logic [LANES-1:0]  r_lane,
  output logic              r_ilv
);
  always_ff @(posedge clk) begin
    r_addr <= addr;
    r_din  <= din;
    if (rst) begin
      r_start   <= 1'b0;
      r_sel     <= 1'b0;
      r_adv     <= 1'b0;
      r_wr_all  <= 1'b0;
      r_wr_byte <= 1'b0;
      r_lane    <= '0;
      r_ilv     <= 1'b0;
    end else begin
      r_start   <= ~bst_proc_n | ~bst_ctrl_n;
      r_sel     <= ~sel0_n & sel1 & ~sel2_n;
      r_adv     <= ~adv_n;
      r_wr_all  <= ~wr_all_n;
      r_wr_byte <= ~wr_byte_n;
      r_lane    <= ~lane_n;
      r_ilv     <= ilv_mode;
    end
  end
endmodule

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int HI_W  = ADDR_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              r_start,
  input  logic              r_sel,
  input  logic              r_adv,
  input  logic              r_ilv,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              op_valid,
  output logic [ADDR_W-1:0] op_addr
);
  logic [ADDR_W-1:0] base;
  beat_t             cnt;
  logic              burst_on;
  logic [ADDR_W-1:0] op_base;
  beat_t             op_cnt;
  beat_t             low_lin, low_ilv;

  always_comb begin
    op_base  = r_start ? r_addr : base;
    op_cnt   = r_start ? beat_t'(0) : (r_adv ? cnt + beat_t'(1) : cnt);
    op_valid = r_start ? r_sel : burst_on;
    low_lin  = op_base[CNT_W-1:0] + op_cnt;
    low_ilv  = op_base[CNT_W-1:0] ^ op_cnt;
    op_addr  = {op_base[ADDR_W-1:CNT_W], (r_ilv ? low_ilv : low_lin)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      cnt      <= '0;
      burst_on <= 1'b0;
    end else begin
      base     <= op_base;
      cnt      <= op_cnt;
      burst_on <= op_valid;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_on && !r_start && r_adv) |=> (cnt == $past(cnt) + beat_t'(1)));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (r_start && r_sel) |=> (cnt == '0 && base == $past(r_addr) && burst_on));
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  we,
  input  logic              re,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re)    rdata[g*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/burst_sram_drive.sv
module burst_sram_drive #(
  parameter int DESEL_CYC = 2,
  localparam int HW       = (DESEL_CYC > 1) ? $clog2(DESEL_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_op,
  input  logic wr_op,
  output logic drive
);
  logic [HW-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive <= 1'b0;
      hold  <= '0;
    end else if (rd_op) begin
      drive <= 1'b1;
      hold  <= HW'(DESEL_CYC - 1);
    end else if (wr_op) begin
      drive <= 1'b0;
      hold  <= '0;
    end else if (drive) begin
      if (hold != '0) hold <= hold - HW'(1);
      else            drive <= 1'b0;
    end
  end

  // R9
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    rd_op |=> drive);
  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (drive && hold != '0 && !wr_op) |=> drive);
  // R11
  wr_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_op && !rd_op) |=> !drive);
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int DESEL_CYC = 2,
  localparam int DW       = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bst_proc_n,
  input  logic              bst_ctrl_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              sel0_n,
  input  logic              sel1,
  input  logic              sel2_n,
  input  logic              oe_n,
  input  logic              ilv_mode,
  input  logic [DW-1:0]     din,
  output logic [DW-1:0]     dout,
  output logic              dout_en
);
  logic [ADDR_W-1:0] r_addr, op_addr;
  logic [DW-1:0]     r_din;
  logic              r_start, r_sel, r_adv, r_wr_all, r_wr_byte, r_ilv;
  logic [LANES-1:0]  r_lane, lane_we;
  logic              op_valid, drive;
  op_e               op;

  burst_sram_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_cap (
    .clk, .rst, .addr, .bst_proc_n, .bst_ctrl_n, .adv_n, .wr_all_n, .wr_byte_n,
    .lane_n, .sel0_n, .sel1, .sel2_n, .ilv_mode, .din,
    .r_addr, .r_din, .r_start, .r_sel, .r_adv, .r_wr_all, .r_wr_byte, .r_lane, .r_ilv
  );

  burst_sram_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst, .r_start, .r_sel, .r_adv, .r_ilv, .r_addr, .op_valid, .op_addr
  );

  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_we[i] = op_valid & (r_wr_all | (r_wr_byte & r_lane[i]));
    if (!op_valid)     op = ST_IDLE;
    else if (|lane_we) op = ST_WRITE;
    else               op = ST_READ;
  end

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk, .addr(op_addr), .we(lane_we), .re(op == ST_READ), .wdata(r_din), .rdata(dout)
  );

  burst_sram_drive #(.DESEL_CYC(DESEL_CYC)) u_drv (
    .clk, .rst, .rd_op(op == ST_READ), .wr_op(op == ST_WRITE), .drive
  );

  assign dout_en = drive & ~oe_n;

  // R8
  desel_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    (r_start && !r_sel) |-> (lane_we == '0));
  // R6
  nolane_read_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !r_wr_all && r_lane == '0) |=> drive);
endmodule

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int AW = 6, LN = 4, LW = 8, DW = LN * LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addr;
  logic bst_proc_n, bst_ctrl_n, adv_n, wr_all_n, wr_byte_n;
  logic [LN-1:0] lane_n;
  logic sel0_n, sel1, sel2_n, oe_n, ilv_mode;
  logic [DW-1:0] din, dout;
  logic dout_en;
  logic [DW-1:0] model [DEPTH];
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  burst_sram u_burst_sram (
    .clk, .rst, .addr, .bst_proc_n, .bst_ctrl_n, .adv_n, .wr_all_n, .wr_byte_n,
    .lane_n, .sel0_n, .sel1, .sel2_n, .oe_n, .ilv_mode, .din, .dout, .dout_en
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    bst_proc_n = 1; bst_ctrl_n = 1; adv_n = 1; wr_all_n = 1; wr_byte_n = 1;
    lane_n = '1; sel0_n = 0; sel1 = 1; sel2_n = 0;
  endtask

  task automatic deselect();
    idle(); bst_proc_n = 0; sel0_n = 1;
  endtask

  // one write cycle; the model follows the lane rules of R6 and R7
  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic all_n, input logic byte_n, input logic [LN-1:0] ln);
    idle(); bst_ctrl_n = 0; addr = a; din = d;
    wr_all_n = all_n; wr_byte_n = byte_n; lane_n = ln;
    for (int i = 0; i < LN; i++)
      if (!all_n || (!byte_n && !ln[i])) model[a][i*LW +: LW] = d[i*LW +: LW];
    step();
    deselect(); step();
  endtask

  task automatic rd1(input logic [AW-1:0] a, output logic [DW-1:0] v);
    idle(); bst_proc_n = 0; addr = a; step();
    deselect(); step();
    v = dout;
    idle(); step();
  endtask

  task automatic t_reset();
    chk("R1 dout_en after reset", DW'(dout_en), '0);
    idle(); adv_n = 0; step(); step(); step();
    chk("R1 advance without start", DW'(dout_en), '0);
    idle(); step();
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++)
      wr_word(AW'(a), DW'(a) * 32'h0103_0507 ^ 32'h5A5A_0000, 1'b0, 1'b1, '1);
  endtask

  task automatic t_burst(input logic [AW-1:0] base, input logic ilv);
    logic [1:0] lo;
    ilv_mode = ilv;
    for (int j = 0; j <= 4; j++) begin
      if (j == 0) begin idle(); bst_proc_n = 0; addr = base; end
      else if (j <= 3) begin idle(); adv_n = 0; end
      else deselect();
      step();
      if (j >= 1) begin
        lo = ilv ? (base[1:0] ^ 2'(j - 1)) : (base[1:0] + 2'(j - 1));
        chk(ilv ? "R3 interleaved beat" : "R2 linear beat", dout, model[{base[AW-1:2], lo}]);
      end
    end
    idle(); ilv_mode = 0; step();
  endtask

  task automatic t_suspend();
    idle(); bst_proc_n = 0; addr = 5; step();
    idle(); step();
    chk("R4 first beat", dout, model[5]);
    adv_n = 0; step();
    chk("R4 held beat repeats", dout, model[5]);
    deselect(); step();
    chk("R4 advanced beat", dout, model[6]);
    idle(); step();
  endtask

  task automatic t_reload();
    idle(); bst_proc_n = 0; addr = 9; step();
    idle(); adv_n = 0; step();
    chk("R5 beat before reload", dout, model[9]);
    idle(); bst_ctrl_n = 0; addr = 33; step();
    chk("R5 second beat", dout, model[10]);
    idle(); adv_n = 0; step();
    chk("R5 reloaded start", dout, model[33]);
    deselect(); step();
    chk("R5 reloaded next", dout, model[34]);
    idle(); step();
  endtask

  task automatic t_bytes();
    logic [DW-1:0] v;
    wr_word(20, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1010);
    rd1(20, v); chk("R6 lanes 0 and 2 only", v, model[20]);
    wr_word(21, 32'h1111_2222, 1'b1, 1'b0, 4'b1111);
    rd1(21, v); chk("R6 no lane enabled", v, model[21]);
    wr_word(22, 32'h3333_4444, 1'b1, 1'b1, 4'b0000);
    rd1(22, v); chk("R6 lanes without byte enable", v, model[22]);
    wr_word(23, 32'hDEAD_BEEF, 1'b0, 1'b1, 4'b1111);
    rd1(23, v); chk("R7 global write all lanes", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_select();
    logic [DW-1:0] v;
    for (int k = 0; k < 3; k++) begin
      idle(); bst_ctrl_n = 0; addr = 40; din = 32'hFFFF_0000 | 32'(k);
      wr_all_n = 0;
      if (k == 0) sel0_n = 1; else if (k == 1) sel1 = 0; else sel2_n = 1;
      step(); idle(); step();
      rd1(40, v); chk("R8 deselected write ignored", v, model[40]);
    end
    idle(); step(); step(); step();
    idle(); bst_proc_n = 0; addr = 41; sel1 = 0; step();
    idle(); step();
    chk("R8 deselected read no drive", DW'(dout_en), '0);
    step();
    chk("R8 deselected read no drive later", DW'(dout_en), '0);
  endtask

  task automatic t_release();
    logic [DW-1:0] v;
    rd1(2, v);
    idle(); bst_proc_n = 0; addr = 3; step();
    deselect(); step();
    chk("R9 data after second edge", dout, model[3]);
    chk("R10 drive cycle 1", DW'(dout_en), 1);
    idle(); step();
    chk("R10 drive cycle 2", DW'(dout_en), 1);
    step();
    chk("R10 released", DW'(dout_en), 0);
    // latency: previous value held one cycle
    idle(); bst_proc_n = 0; addr = 4; step();
    deselect(); chk("R9 old data before edge", dout, model[3]);
    step(); chk("R9 new data", dout, model[4]);
    idle(); step(); step();
    // output enable gating
    oe_n = 1;
    idle(); bst_proc_n = 0; addr = 7; step();
    deselect(); step();
    chk("R11 oe_n high blocks drive", DW'(dout_en), 0);
    oe_n = 0; idle(); step(); step(); step();
    // write ends the drive
    idle(); bst_proc_n = 0; addr = 8; step();
    idle(); bst_ctrl_n = 0; addr = 50; din = 32'h0F0F_F0F0; wr_all_n = 0;
    model[50] = 32'h0F0F_F0F0; step();
    deselect();
    chk("R11 drive during read", DW'(dout_en), 1);
    step();
    chk("R11 write releases drive", DW'(dout_en), 0);
    idle(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL all: watchdog expired, actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(); addr = '0; din = '0; oe_n = 0; ilv_mode = 0;
    rst = 1;
    repeat (3) step();
    rst = 0;
    step();
    t_reset();
    t_fill();
    for (int o = 0; o < 4; o++) begin
      t_burst(AW'(8 + o), 1'b0);
      t_burst(AW'(8 + o), 1'b1);
      t_burst(AW'(60 + o), 1'b0);
      t_burst(AW'(60 + o), 1'b1);
    end
    t_suspend();
    t_reload();
    t_bytes();
    t_select();
    t_release();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule